// File: doc/BRIEF.md
# Ring Oscillator Phase Calculator

This block sits in the digital half of a frequency-to-digital converter built around a ring oscillator with 13 stages. Once per reference period it receives a snapshot of the ring: the levels of all stage outputs and the value of a free-running 8-bit cycle counter. Both arrive already synchronized and qualified by a one-cycle valid strobe. From each snapshot it forms a coarse phase-error sample and a fine quantization-noise correction term.

The coarse path takes the counter's advance since the previous snapshot and, because the counter is never cleared, works in modulo arithmetic. The top bit of that advance is dropped. The result is the number of oscillator cycles in the period. A programmable nominal count is subtracted from it, and the remainder is summed in a saturating accumulator. A clipper limits the magnitude of the reported value so that large errors during acquisition cannot slow the loop down. The fine path decodes the stage pattern into one of 26 sub-cycle positions and reports how far that position moved since the previous snapshot. The loop adds this value after its own accumulator to cancel most of the coarse quantization error.

Top module: `ring_phase_calc`

## Requirements
- R1: The cycle count for a period is (current count minus previous count) modulo 256 with bit 7 forced to zero, giving a value from 0 to 127.
- R2: Each valid sample after the first adds (cycle count minus nominal) to a signed accumulator, and `phase_err` reports the updated accumulator.
- R3: The nominal count used is `nominal` clamped to the range 40 to 80.
- R4: The accumulator is 12-bit two's complement and saturates at 2047 and -2048 instead of wrapping.
- R5: `phase_err` is the accumulator limited to the range -2 to +2, as 3-bit two's complement.
- R6: Legal tap patterns decode as follows. Code s from 0 to 12 has taps below bit s high and the rest low. Code s from 13 to 25 has taps below bit s-13 low and the rest high. `fine_code` is that code, 0 to 25.
- R7: A pattern that is not legal decodes to the number of high taps when tap 12 is low, or to 26 minus the number of high taps when tap 12 is high. It also sets `tap_fault`, which stays high until reset.
- R8: `fine_step` is the new fine code minus the previous one, as 6-bit two's complement.
- R9: All outputs change only in the clock after `snap_valid`. `out_valid` is high for exactly that clock, and otherwise every output holds.
- R10: The first valid sample after reset only records the count and the code. The accumulator is unchanged and `fine_step` is 0.
- R11: Reset clears the accumulator, `phase_err`, `fine_code`, `fine_step`, `tap_fault` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_valid | input | 1 | One-cycle strobe qualifying a snapshot |
| ring_taps | input | 13 | Sampled stage outputs, bit i is stage i |
| cycle_cnt | input | 8 | Sampled free-running cycle counter |
| nominal | input | 7 | Expected cycles per reference period |
| phase_err | output | 3 | Clipped accumulated coarse phase error |
| fine_code | output | 5 | Decoded sub-cycle position |
| fine_step | output | 6 | First difference of the fine code |
| tap_fault | output | 1 | Sticky illegal-pattern flag |
| out_valid | output | 1 | Outputs refreshed this cycle |

## Verification
Every result is registered exactly once, so each output for a snapshot presented on one clock edge is due on the next edge. The bench drives a snapshot on a falling edge for one cycle, lets one rising edge pass, and samples on the following falling edge. It checks `out_valid` at that same point. For the idle and hold checks, the inputs are changed with the strobe low, two rising edges pass, and the outputs must be unchanged. The saturation checks sample only after each chain of accumulating snapshots has finished, so the expected value follows from the arithmetic of R3 to R5 alone.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

   // Limits an integer to an inclusive window.
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction

   // Counts the ones in a tap word of up to 32 bits.
   function automatic int ones_in(input logic [31:0] w, input int n);
      int c;
      c = 0;
      for (int i = 0; i < n; i++) c = c + int'(w[i]);
      return c;
   endfunction

endpackage

// File: rtl/rpc_fine_decode.sv
module rpc_fine_decode #(
   parameter int STAGES = 13,
   localparam int CODE_N = 2 * STAGES,
   localparam int CODE_W = $clog2(CODE_N)
) (
   input  logic [STAGES-1:0] taps,
   output logic [CODE_W-1:0] code,
   output logic              illegal
);
   import rpc_pkg::*;

   if (STAGES < 3 || STAGES > 31) begin : g_bad_stages
      $error("rpc_fine_decode: STAGES out of supported range");
   end

   int                 hi_cnt;
   int                 code_i;
   logic [STAGES-1:0]  legal_pat;

   always_comb begin
      hi_cnt = ones_in(32'(taps), STAGES);
      if (!taps[STAGES-1]) code_i = hi_cnt;
      else if (hi_cnt == STAGES) code_i = STAGES;
      else code_i = CODE_N - hi_cnt;
      code = CODE_W'(code_i);
   end

   // Rebuild the legal pattern for the decoded code, one bit per stage.
   for (genvar i = 0; i < STAGES; i++) begin : g_pat
      assign legal_pat[i] = (code_i < STAGES) ? (i < code_i) : !(i < (code_i - STAGES));
   end

   assign illegal = (legal_pat != taps);

endmodule

// File: rtl/rpc_coarse_path.sv
module rpc_coarse_path #(
   parameter int CNT_W    = 8,
   parameter int ACC_W    = 12,
   parameter int NOM_W    = 7,
   parameter int NOM_MIN  = 40,
   parameter int NOM_MAX  = 80,
   parameter int CLIP     = 2,
   localparam int OUT_W   = $clog2(CLIP + 1) + 1,
   localparam int DIFF_W  = CNT_W - 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    prime,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [NOM_W-1:0]        nominal,
   output logic signed [OUT_W-1:0] phase
);
   import rpc_pkg::*;

   localparam int ACC_MAX = (2 ** (ACC_W - 1)) - 1;
   localparam int ACC_MIN = -(2 ** (ACC_W - 1));

   if (NOM_MIN > NOM_MAX || NOM_MAX >= 2 ** NOM_W) begin : g_bad_nom
      $error("rpc_coarse_path: nominal window does not fit");
   end
   if (CLIP < 1 || CLIP > ACC_MAX) begin : g_bad_clip
      $error("rpc_coarse_path: clip limit outside accumulator range");
   end
   if (ACC_W < CNT_W + 1 || ACC_W > 30) begin : g_bad_acc
      $error("rpc_coarse_path: accumulator width unsuitable");
   end

   logic [CNT_W-1:0]        prev_cnt;
   logic signed [ACC_W-1:0] acc;
   logic [CNT_W-1:0]        advance;
   logic [DIFF_W-1:0]       cycles;
   int                      nom_used;
   int                      sum;
   logic signed [ACC_W-1:0] acc_upd;

   always_comb begin
      advance  = cnt - prev_cnt;
      cycles   = advance[DIFF_W-1:0];
      nom_used = clamp_int(int'(nominal), NOM_MIN, NOM_MAX);
      sum      = int'(acc) + int'(cycles) - nom_used;
      acc_upd  = prime ? acc : ACC_W'(clamp_int(sum, ACC_MIN, ACC_MAX));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_cnt <= '0;
         acc      <= '0;
         phase    <= '0;
      end else if (step) begin
         prev_cnt <= cnt;
         acc      <= acc_upd;
         phase    <= OUT_W'(clamp_int(int'(acc_upd), -CLIP, CLIP));
      end
   end

   // R5: the reported phase never leaves the clip window
   a_r5_clip_window: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(phase) <= CLIP) && (int'(phase) >= -CLIP));

   // R4: a saturated accumulator does not jump to the opposite rail
   a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acc) == ACC_MAX) |=> (int'(acc) != ACC_MIN));

endmodule

// File: rtl/ring_phase_calc.sv
module ring_phase_calc #(
   parameter int STAGES  = 13,
   parameter int CNT_W   = 8,
   parameter int ACC_W   = 12,
   parameter int NOM_W   = 7,
   parameter int NOM_MIN = 40,
   parameter int NOM_MAX = 80,
   parameter int CLIP    = 2,
   localparam int CODE_N = 2 * STAGES,
   localparam int CODE_W = $clog2(CODE_N),
   localparam int OUT_W  = $clog2(CLIP + 1) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snap_valid,
   input  logic [STAGES-1:0]        ring_taps,
   input  logic [CNT_W-1:0]         cycle_cnt,
   input  logic [NOM_W-1:0]         nominal,
   output logic signed [OUT_W-1:0]  phase_err,
   output logic [CODE_W-1:0]        fine_code,
   output logic signed [CODE_W:0]   fine_step,
   output logic                     tap_fault,
   output logic                     out_valid
);

   logic              primed;
   logic              first;
   logic [CODE_W-1:0] dec_code;
   logic              dec_bad;

   assign first = snap_valid && !primed;

   rpc_fine_decode #(.STAGES(STAGES)) u_fine (
      .taps    (ring_taps),
      .code    (dec_code),
      .illegal (dec_bad)
   );

   rpc_coarse_path #(
      .CNT_W(CNT_W), .ACC_W(ACC_W), .NOM_W(NOM_W),
      .NOM_MIN(NOM_MIN), .NOM_MAX(NOM_MAX), .CLIP(CLIP)
   ) u_coarse (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (snap_valid),
      .prime   (first),
      .cnt     (cycle_cnt),
      .nominal (nominal),
      .phase   (phase_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed    <= 1'b0;
         fine_code <= '0;
         fine_step <= '0;
         tap_fault <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= snap_valid;
         if (snap_valid) begin
            primed    <= 1'b1;
            fine_code <= dec_code;
            fine_step <= first ? '0 : ($signed({1'b0, dec_code}) - $signed({1'b0, fine_code}));
            if (dec_bad) tap_fault <= 1'b1;
         end
      end
   end

   // R9: one output strobe per snapshot, in the following cycle
   a_r9_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |=> out_valid);
   a_r9_no_extra_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_valid |=> !out_valid);
   // R9: without a snapshot the outputs hold
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_valid |=> ($stable(phase_err) && $stable(fine_code) && $stable(fine_step)));
   // R7: the fault flag is sticky
   a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tap_fault |=> tap_fault);
   // R6: decoded code stays inside the 26 positions
   a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fine_code) < CODE_N);

endmodule

// File: tb/ring_phase_calc_test.sv
module ring_phase_calc_test;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              snap_valid = 1'b0;
   logic [12:0]       ring_taps = '0;
   logic [7:0]        cycle_cnt = '0;
   logic [6:0]        nominal = 7'd60;
   logic signed [2:0] phase_err;
   logic [4:0]        fine_code;
   logic signed [5:0] fine_step;
   logic              tap_fault;
   logic              out_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ring_phase_calc uut (
      .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid),
      .ring_taps(ring_taps), .cycle_cnt(cycle_cnt), .nominal(nominal),
      .phase_err(phase_err), .fine_code(fine_code), .fine_step(fine_step),
      .tap_fault(tap_fault), .out_valid(out_valid)
   );

   // Legal tap pattern for a code, from R6.
   function automatic logic [12:0] pat(input int c);
      logic [12:0] t;
      for (int i = 0; i < 13; i++) t[i] = (c < 13) ? (i < c) : !(i < c - 13);
      return t;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Presents one snapshot for one cycle; returns at the sampling point.
   task automatic snap(input logic [12:0] t, input logic [7:0] c, input int nom);
      @(negedge clk);
      snap_valid = 1'b1;
      ring_taps  = t;
      cycle_cnt  = c;
      nominal    = 7'(nom);
      @(negedge clk);
      snap_valid = 1'b0;
   endtask

   // code, count, nominal, expected phase, expected step
   localparam int VEC [8][5] = '{
      '{ 5,  10, 60,  0,   0},
      '{ 7,  70, 60,  0,   2},
      '{20, 131, 60,  1,  13},
      '{25, 192, 60,  2,   5},
      '{ 0, 253, 60,  2, -25},
      '{13,  55, 60,  1,  13},
      '{12, 233, 60, -2,  -1},
      '{12,  47, 60,  1,   0}
   };

   initial begin
      logic [7:0] cnt;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 phase", int'(phase_err), 0);
      check("R11 code", int'(fine_code), 0);
      check("R11 step", int'(fine_step), 0);
      check("R11 fault", int'(tap_fault), 0);
      check("R11 valid", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R5 R6 R8 R10: table walk
      for (int k = 0; k < 8; k++) begin
         snap(pat(VEC[k][0]), 8'(VEC[k][1]), VEC[k][2]);
         check("R9 valid", int'(out_valid), 1);
         check("R2/R5 phase", int'(phase_err), VEC[k][3]);
         check("R6 code", int'(fine_code), VEC[k][0]);
         check("R8 step", int'(fine_step), VEC[k][4]);
      end
      cnt = 8'd47;

      // R7: illegal pattern
      cnt = cnt + 8'd60;
      snap(13'h0005, cnt, 60);
      check("R7 code", int'(fine_code), 2);
      check("R7 fault", int'(tap_fault), 1);
      check("R8 step", int'(fine_step), -10);
      cnt = cnt + 8'd60;
      snap(pat(3), cnt, 60);
      check("R7 sticky", int'(tap_fault), 1);
      check("R6 code", int'(fine_code), 3);
      check("R2 phase", int'(phase_err), 1);

      // R9: inputs move with no strobe
      @(negedge clk);
      ring_taps = pat(22);
      cycle_cnt = cnt + 8'd9;
      nominal   = 7'd40;
      @(negedge clk);
      @(negedge clk);
      check("R9 hold phase", int'(phase_err), 1);
      check("R9 hold code", int'(fine_code), 3);
      check("R9 idle valid", int'(out_valid), 0);

      // R3: nominal clamped at both ends
      cnt = cnt + 8'd40;
      snap(pat(3), cnt, 20);
      check("R3 low clamp", int'(phase_err), 1);
      cnt = cnt + 8'd80;
      snap(pat(3), cnt, 100);
      check("R3 high clamp", int'(phase_err), 1);

      // R4: positive saturation, then back down exactly
      for (int k = 0; k < 30; k++) begin cnt = cnt + 8'd127; snap(pat(3), cnt, 40); end
      for (int k = 0; k < 25; k++) snap(pat(3), cnt, 80);
      check("R4 pos sat 47", int'(phase_err), 2);
      snap(pat(3), cnt, 47);
      check("R4 pos sat 0", int'(phase_err), 0);
      cnt = cnt + 8'd40;
      snap(pat(3), cnt, 41);
      check("R4 pos sat -1", int'(phase_err), -1);

      // R4: negative saturation
      for (int k = 0; k < 30; k++) snap(pat(3), cnt, 80);
      for (int k = 0; k < 25; k++) begin cnt = cnt + 8'd120; snap(pat(3), cnt, 40); end
      check("R4 neg sat -48", int'(phase_err), -2);
      cnt = cnt + 8'd88;
      snap(pat(3), cnt, 40);
      check("R4 neg sat 0", int'(phase_err), 0);
      cnt = cnt + 8'd41;
      snap(pat(3), cnt, 40);
      check("R4 neg sat +1", int'(phase_err), 1);

      // R11 then R10: reset mid-run and priming
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 fault clear", int'(tap_fault), 0);
      check("R11 phase clear", int'(phase_err), 0);
      cnt = cnt + 8'd200;
      snap(pat(9), cnt, 60);
      check("R10 prime phase", int'(phase_err), 0);
      check("R10 prime step", int'(fine_step), 0);
      check("R10 prime code", int'(fine_code), 9);
      cnt = cnt + 8'd61;
      snap(pat(9), cnt, 60);
      check("R10 after prime", int'(phase_err), 1);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule